// File: doc/BRIEF.md
# Nibble Serial Register Access Master

This block lets a host read or write one 4-bit register inside a clock chip over a three-wire serial link. The link has a chip enable, a serial clock and one data line that both ends share. The host holds the enable input high for as long as it wants the chip selected. It then issues requests, each carrying a direction flag, a 4-bit address and, for writes, a 4-bit value. The block accepts one request at a time and sends the matching frame. It pulses `done` when the frame ends, and `rdata` then holds the nibble read back.

Every frame opens with a 4-bit control header: a don't-care bit, a read flag, an address-phase flag and a data-phase flag. The address follows, most significant bit first. A write then sends a second header and the data nibble, and the data line stays driven throughout. A read releases the data line and leaves it quiet for one serial period. The block then clocks eight bits in, drops the first four and keeps the last four.

The serial clock comes from the system clock through a divider. The host sets the divider, and the block latches it when it accepts a request.

Top module: `nib_serial_master`

## Requirements
- R1: While reset is asserted and just after it ends, `ce` and `sdo_oe` are 0, `sclk` is 1, `done` and `err` are 0, and `ready` is 1.
- R2: A read frame drives 8 clocked bits, in this order: the header 1,1,1,0, then `addr[3]` down to `addr[0]`.
- R3: A write frame drives 16 clocked bits, in this order: the header 1,0,1,0, then `addr[3..0]`, then the header 1,0,0,1, then `wdata[3..0]`. `sdo_oe` stays high for every bit of the frame.
- R4: After the eighth bit of a read, `sdo_oe` falls. At least 2*(`clk_div`+1) system cycles then pass before the first falling `sclk` edge of the input phase, and `sclk` stays high during that gap.
- R5: A read clocks in eight more bits. The first four are dropped, and the last four are returned on `rdata` as bit 3 down to bit 0.
- R6: Each half of a serial bit lasts `clk_div`+1 system cycles. `sclk` idles high. `sdo` changes only while `sclk` is low (data is launched on the falling edge). A write therefore keeps `ready` low for 32*(`clk_div`+1) cycles, and a read for 34*(`clk_div`+1).
- R7: `done` is a one-cycle pulse in the cycle `ready` returns high. A request made while `ready` is low is ignored and changes neither the frame nor its length.
- R8: `ce` follows `en_req` one cycle later. It stays high across any number of frames.
- R9: A request while `ready` is high and `ce` is low starts no frame. Instead it raises `err` for one cycle, and `ready` stays high.
- R10: The divider value is latched when a request is accepted. A change of `clk_div` during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial half-period length minus one, in system cycles |
| en_req | input | 1 | Host request to select the chip |
| req | input | 1 | Request strobe, accepted when `ready` is high |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Nibble to write |
| ready | output | 1 | Block is idle and can take a request |
| rdata | output | 4 | Nibble returned by the last read |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | One-cycle pulse: request rejected because `ce` was low |
| ce | output | 1 | Chip enable to the clock chip |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data driven toward the chip |
| sdo_oe | output | 1 | Output enable for the shared data line |
| sdi | input | 1 | Serial data read from the shared data line |

## Verification
Reads and writes are run with several addresses and nibbles and with divider values 0 to 3. Comparing the bits seen on rising serial clock edges shows whether the header, address, second header and data come out in the right order and direction. The modelled chip drives the complement of the data nibble during the four discarded bits, so a capture that starts one bit early or late returns a visibly wrong nibble. Frame length and the turnaround gap are measured per divider value, which separates a wrong half-period from a missing quiet slot. Directed runs fire a request mid-frame, change the divider mid-frame, and request with enable low. These show whether the block ignores a stray request, latches the divider, and rejects a request made without enable.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
    localparam int NIB_W       = 4;
    localparam int FRAME_W     = 16;
    localparam int RD_TX_BITS  = 8;
    localparam int RX_BITS     = 8;
    localparam int CNT_W       = $clog2(FRAME_W);

    // header layout: dont-care, read flag, address phase, data phase
    localparam logic [NIB_W-1:0] HDR_RD      = 4'b1110;
    localparam logic [NIB_W-1:0] HDR_WR_ADDR = 4'b1010;
    localparam logic [NIB_W-1:0] HDR_WR_DATA = 4'b1001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TURN,
        ST_RECV
    } seq_st_e;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic             rd,
        input logic [NIB_W-1:0] a,
        input logic [NIB_W-1:0] d
    );
        if (rd)
            return {HDR_RD, a, {(FRAME_W-2*NIB_W){1'b0}}};
        else
            return {HDR_WR_ADDR, a, HDR_WR_DATA, d};
    endfunction
endpackage

// File: rtl/nsm_clkdiv.sv
module nsm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half,
    output logic             slot_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
    } div_reg_t;

    div_reg_t div_q, div_d;

    always_comb begin
        div_d = div_q;
        if (!run) begin
            div_d.cnt  = '0;
            div_d.half = 1'b0;
        end else if (div_q.cnt == div) begin
            div_d.cnt  = '0;
            div_d.half = ~div_q.half;
        end else begin
            div_d.cnt  = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign half     = div_q.half;
    assign slot_end = run && div_q.half && (div_q.cnt == div);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_q.cnt <= div)); // R6
endmodule

// File: rtl/nsm_seq.sv
module nsm_seq import nsm_pkg::*; #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_nwr,
    input  logic [NIB_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    input  logic [DIV_W-1:0] div_in,
    input  logic             sdi,
    input  logic             half,
    input  logic             slot_end,
    output logic             run_o,
    output logic [DIV_W-1:0] div_o,
    output logic             sclk_o,
    output logic             sdo_o,
    output logic             oe_o,
    output logic             done_o,
    output logic [NIB_W-1:0] rdata_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] LAST_RD_TX = CNT_W'(RD_TX_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_WR_TX = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_RX    = CNT_W'(RX_BITS - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [FRAME_W-1:0] tx;
        logic [NIB_W-1:0] rx;
        logic [CNT_W-1:0] bcnt;
        logic             rd;
        logic [DIV_W-1:0] div;
        logic             done;
        logic [NIB_W-1:0] rdata;
    } seq_reg_t;

    seq_reg_t seq_q, seq_d;
    logic [CNT_W-1:0] last_tx;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        last_tx    = seq_q.rd ? LAST_RD_TX : LAST_WR_TX;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_SHIFT;
                    seq_d.tx   = build_frame(rd_nwr, addr, wdata);
                    seq_d.rd   = rd_nwr;
                    seq_d.div  = div_in;
                    seq_d.bcnt = '0;
                end
            end
            ST_SHIFT: begin
                if (slot_end) begin
                    seq_d.tx   = {seq_q.tx[FRAME_W-2:0], 1'b0};
                    seq_d.bcnt = seq_q.bcnt + 1'b1;
                    if (seq_q.bcnt == last_tx) begin
                        seq_d.bcnt = '0;
                        if (seq_q.rd) begin
                            seq_d.st = ST_TURN;
                        end else begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_TURN: begin
                if (slot_end) seq_d.st = ST_RECV;
            end
            ST_RECV: begin
                if (slot_end) begin
                    seq_d.rx   = {seq_q.rx[NIB_W-2:0], sdi};
                    seq_d.bcnt = seq_q.bcnt + 1'b1;
                    if (seq_q.bcnt == LAST_RX) begin
                        seq_d.st    = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.rdata = {seq_q.rx[NIB_W-2:0], sdi};
                        seq_d.bcnt  = '0;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_o   = (seq_q.st != ST_IDLE);
    assign busy_o  = run_o;
    assign div_o   = seq_q.div;
    assign sclk_o  = (seq_q.st == ST_SHIFT || seq_q.st == ST_RECV) ? half : 1'b1;
    assign sdo_o   = (seq_q.st == ST_SHIFT) ? seq_q.tx[FRAME_W-1] : 1'b0;
    assign oe_o    = (seq_q.st == ST_SHIFT);
    assign done_o  = seq_q.done;
    assign rdata_o = seq_q.rdata;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && oe_o && $past(oe_o)) |-> $stable(sdo_o)); // R6
    AST_WR_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !seq_q.rd) |-> oe_o); // R3
    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TURN) |-> (sclk_o && !oe_o)); // R4
    AST_RECV_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RECV) |-> !oe_o); // R5
endmodule

// File: rtl/nib_serial_master.sv
module nib_serial_master import nsm_pkg::*; #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             en_req,
    input  logic             req,
    input  logic             rd_nwr,
    input  logic [3:0]       addr,
    input  logic [3:0]       wdata,
    output logic             ready,
    output logic [3:0]       rdata,
    output logic             done,
    output logic             err,
    output logic             ce,
    output logic             sclk,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             sdi
);
    typedef struct packed {
        logic ce;
        logic err;
    } top_reg_t;

    top_reg_t         top_q, top_d;
    logic             busy, start, run, half, slot_end;
    logic [DIV_W-1:0] div_lat;

    always_comb begin
        top_d     = top_q;
        top_d.ce  = en_req;
        top_d.err = req && !busy && !top_q.ce;
        start     = req && !busy && top_q.ce;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    nsm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (div_lat),
        .half     (half),
        .slot_end (slot_end)
    );

    nsm_seq #(.DIV_W(DIV_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_nwr   (rd_nwr),
        .addr     (addr),
        .wdata    (wdata),
        .div_in   (clk_div),
        .sdi      (sdi),
        .half     (half),
        .slot_end (slot_end),
        .run_o    (run),
        .div_o    (div_lat),
        .sclk_o   (sclk),
        .sdo_o    (sdo),
        .oe_o     (sdo_oe),
        .done_o   (done),
        .rdata_o  (rdata),
        .busy_o   (busy)
    );

    assign ready = !busy;
    assign ce    = top_q.ce;
    assign err   = top_q.err;

    AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ready); // R9
    AST_START_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ce)); // R9
    AST_CE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ce == $past(en_req))); // R8
    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sclk && !sdo_oe)); // R6
endmodule

// File: tb/nib_serial_master_tb_top.sv
module nib_serial_master_tb_top;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, en_req, req, rd_nwr, sdi;
    logic [3:0]       addr, wdata;
    logic [DIV_W-1:0] clk_div;
    logic             ready, done, err, ce, sclk, sdo, sdo_oe;
    logic [3:0]       rdata;

    int checks = 0;
    int errors = 0;

    nib_serial_master #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .en_req(en_req),
        .req(req), .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .done(done), .err(err), .ce(ce),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    // chip model: counts falling edges; after 8 driven bits it answers
    int          neg_cnt;
    logic [3:0]  slave_nib;
    logic [15:0] cap;
    int          cap_n;
    time         oe_fall_t, first_rx_t;

    always @(negedge sclk) begin
        int idx;
        neg_cnt = neg_cnt + 1;
        if (neg_cnt > 8) begin
            idx = neg_cnt - 9;
            if (idx == 0) first_rx_t = $time;
            if (idx < 4) sdi <= ~slave_nib[3-idx];
            else if (idx < 8) sdi <= slave_nib[7-idx];
        end
    end

    always @(posedge sclk) begin
        if (sdo_oe) begin
            cap   = {cap[14:0], sdo};
            cap_n = cap_n + 1;
        end
    end

    always @(negedge sdo_oe) oe_fall_t = $time;

    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt = wd_cnt + 1;
        if (wd_cnt > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd_cnt, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit rd, input logic [3:0] a, input logic [3:0] wd,
                        input logic [3:0] sn, input logic [7:0] dv,
                        input bit poke, input bit swap, output int lowcnt);
        int guard;
        neg_cnt   = 0;
        cap       = '0;
        cap_n     = 0;
        slave_nib = sn;
        @(negedge clk);
        rd_nwr = rd; addr = a; wdata = wd; clk_div = dv; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (swap) clk_div = dv + 8'd3;
        lowcnt = ready ? 0 : 1;
        guard  = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard = guard + 1;
            if (!ready) lowcnt = lowcnt + 1;
            if (poke && guard == 5) begin
                req = 1'b1; rd_nwr = ~rd; addr = ~a; wdata = ~wd;
            end else if (poke && guard == 6) begin
                req = 1'b0;
            end
        end
        if (guard >= 5000) chk(1'b0, "R7 frame never ended", guard, 0);
    endtask

    // {rd, addr, wdata, slave nibble, divider}
    localparam logic [20:0] VEC [0:5] = '{
        {1'b1, 4'h5, 4'h0, 4'hA, 8'd0},
        {1'b0, 4'hC, 4'h3, 4'h0, 8'd1},
        {1'b1, 4'hF, 4'h0, 4'h1, 8'd2},
        {1'b0, 4'h0, 4'hF, 4'h0, 8'd0},
        {1'b1, 4'h8, 4'h0, 4'h6, 8'd3},
        {1'b0, 4'h7, 4'h9, 4'h0, 8'd2}
    };

    initial begin
        int lc;
        rst_n = 1'b0; en_req = 1'b0; req = 1'b0; rd_nwr = 1'b0;
        addr = '0; wdata = '0; clk_div = '0; sdi = 1'b0;
        neg_cnt = 0; cap = '0; cap_n = 0; slave_nib = '0;
        oe_fall_t = 0; first_rx_t = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(ce == 0 && sdo_oe == 0 && sclk == 1 && ready == 1, "R1 reset outputs",
            {ce, sdo_oe, sclk, ready}, 4'b0011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && err == 0 && ready == 1 && sclk == 1, "R1 after reset",
            {done, err, ready, sclk}, 4'b0011);

        // R9: request without enable
        neg_cnt = 0;
        req = 1'b1; rd_nwr = 1'b1; addr = 4'h2;
        @(negedge clk);
        req = 1'b0;
        chk(err == 1 && ready == 1, "R9 err pulse while idle", {err, ready}, 2'b11);
        @(negedge clk);
        chk(err == 0, "R9 err is one cycle", err, 0);
        repeat (4) @(negedge clk);
        chk(neg_cnt == 0 && done == 0, "R9 no frame started", neg_cnt, 0);

        // R8: enable follows one cycle later
        en_req = 1'b1;
        @(negedge clk);
        chk(ce == 1, "R8 ce follows en_req", ce, 1);

        for (int i = 0; i < 6; i++) begin
            logic       v_rd;
            logic [3:0] v_a, v_wd, v_sn;
            logic [7:0] v_dv;
            {v_rd, v_a, v_wd, v_sn, v_dv} = VEC[i];
            xfer(v_rd, v_a, v_wd, v_sn, v_dv, 1'b0, 1'b0, lc);
            if (v_rd) begin
                chk(cap_n == 8 && cap[7:0] == {4'b1110, v_a}, "R2 read header and address",
                    {cap_n[7:0], cap[7:0]}, {8'd8, 4'b1110, v_a});
                chk(rdata == v_sn, "R5 read nibble", rdata, v_sn);
                chk(first_rx_t - oe_fall_t >= 20 * (v_dv + 1), "R4 turnaround gap",
                    first_rx_t - oe_fall_t, 20 * (v_dv + 1));
                chk(lc == 34 * (v_dv + 1), "R6 read frame length", lc, 34 * (v_dv + 1));
            end else begin
                chk(cap_n == 16 && cap == {4'b1010, v_a, 4'b1001, v_wd}, "R3 write frame bits",
                    cap, {4'b1010, v_a, 4'b1001, v_wd});
                chk(lc == 32 * (v_dv + 1), "R6 write frame length", lc, 32 * (v_dv + 1));
            end
            chk(ready == 1 && ce == 1, "R8 ce held across frames", {ready, ce}, 2'b11);
            @(negedge clk);
            chk(done == 0 && sclk == 1, "R7 done one cycle, R6 sclk idles high",
                {done, sclk}, 2'b01);
        end

        // R7: request while busy is ignored
        xfer(1'b0, 4'h3, 4'h6, 4'h0, 8'd1, 1'b1, 1'b0, lc);
        chk(cap == {4'b1010, 4'h3, 4'b1001, 4'h6} && cap_n == 16, "R7 busy request ignored",
            cap, {4'b1010, 4'h3, 4'b1001, 4'h6});
        chk(lc == 64, "R7 frame length unchanged", lc, 64);
        repeat (3) @(negedge clk);
        chk(ready == 1 && done == 0, "R7 no second frame", {ready, done}, 2'b10);

        // R10: divider change mid-frame
        xfer(1'b1, 4'h9, 4'h0, 4'h5, 8'd1, 1'b0, 1'b1, lc);
        chk(lc == 68, "R10 divider latched at accept", lc, 68);
        chk(rdata == 4'h5, "R10 R5 read nibble with divider change", rdata, 4'h5);

        // R8: enable drop
        en_req = 1'b0;
        @(negedge clk);
        chk(ce == 0, "R8 ce falls after en_req", ce, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule